// File: doc/BRIEF.md
# Cache Maintenance Address Sequencer

This block converts a single cache maintenance command into a stream of per-line operation requests for the cache state logic. In region mode the command carries a start address and a byte length. The block issues one hit-type request for every cache line that the byte range overlaps, and it counts lines from the start address's offset within its line, so an unaligned range gets its extra line. In whole-cache mode the block walks every index from address zero. It works in steps of four lines and places the lanes at zero to three line sizes above a base that then moves up by four lines. The number of steps is divided by the way count when the operation touches all ways at once.

Every command ends with a sync phase. The block waits until the cache reports that it is no longer busy, and then raises a one-cycle done pulse. Requests leave over a valid/ready handshake. A new command is taken only while the block is idle.

Top module: `cache_maint_seq`

## Requirements
- R1: After reset the block is idle: `cmd_ready` is 1, and `op_valid` and `done` are 0.
- R2: In region mode the number of requests is (len + (addr mod LINE) + LINE − 1) >> LINE_LOG2. The first request is at addr with its low LINE_LOG2 bits cleared, and each later request is one line size above the previous one.
- R3: A region command whose computed line count is zero issues no request, and it still completes through the sync phase with a done pulse.
- R4: In whole-cache mode the block issues 4 × CACHE_BYTES / (LINE × W × 4) requests. Request k of a step goes to base + k × LINE for k = 0..3, with base starting at 0 and then advancing by 4 × LINE.
- R5: The divisor W is the way count WAYS for the invalidate operation (`cmd_op` = 0) and 1 for every other operation code (1 writeback, 2 writeback-and-invalidate, 3 lock, 4 unlock).
- R6: `op_code` is {mode, op}: bit 3 is 1 for whole-cache (index) requests and 0 for region (hit) requests, and bits 2:0 repeat the command's `cmd_op`.
- R7: While `op_valid` is high and `op_ready` is low, the request holds valid, address and code unchanged. The address advances only on a transfer.
- R8: Once the last request has transferred (or at once for a zero-line command), the block waits while `cache_busy` is 1. In the first cycle after it samples `cache_busy` at 0, `done` is 1 for exactly one cycle.
- R9: `cmd_valid` is ignored while a command is in progress (`cmd_ready` is 0). The request stream in progress is unaffected.
- R10: Every request address has its low LINE_LOG2 bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_whole | input | 1 | 1 selects whole-cache sweep, 0 region mode |
| cmd_op | input | 3 | Operation code (0 invalidate, 1 writeback, 2 writeback+invalidate, 3 lock, 4 unlock) |
| cmd_addr | input | ADDR_W | Region start byte address |
| cmd_len | input | LEN_W | Region length in bytes |
| op_valid | output | 1 | Line request present |
| op_ready | input | 1 | Cache state logic accepts the request |
| op_code | output | 4 | {index-mode flag, operation} |
| op_addr | output | ADDR_W | Line-aligned request address |
| cache_busy | input | 1 | Earlier cache operations still in flight |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets unaligned ranges. Ranges that cross a line boundary by a few bytes or fit inside one line show whether the offset is counted, because a design that ignores it drops the last line. Zero-length commands expose a down-counter that wraps and sends thousands of requests. Whole-cache sweeps with invalidate and with another operation show whether the way divisor is picked per command, since a wrong choice halves or doubles the request count. Stalled handshakes, commands pushed mid-stream and a cache that stays busy catch requests that slip past a stall, a second command that corrupts the first, and a done pulse that fires early or lasts more than one cycle.

// File: rtl/cache_maint_seq.sv
module cache_maint_seq #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CACHE_BYTES = 1024,
  parameter int LINE_LOG2   = 4,
  parameter int WAYS        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_whole,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [3:0]        op_code,
  output logic [ADDR_W-1:0] op_addr,
  input  logic              cache_busy,
  output logic              done
);
  localparam int LINE       = 1 << LINE_LOG2;
  localparam int CNT_W      = LEN_W + 2;
  localparam int SWEEP_ONE  = CACHE_BYTES / LINE;
  localparam int SWEEP_WAYS = CACHE_BYTES / (LINE * WAYS);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(LINE - 1);
  localparam logic [2:0] OP_INVAL = 3'd0;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_SYNC} state_t;

  state_t            state;
  logic              whole_q;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        lane_q;
  logic [CNT_W-1:0]  left_q;
  logic              done_q;

  initial begin : p_cfg
    AST_CFG_DIVISIBLE: assert (CACHE_BYTES % (LINE * WAYS * 4) == 0) // R4
      else $error("cache size not a multiple of line*ways*4");
    AST_CFG_RANGE: assert (LINE >= 16 && LINE <= 64 && WAYS >= 1 && WAYS <= 4 && CACHE_BYTES >= 1024) // R5
      else $error("cache geometry out of range");
    AST_CFG_COUNT: assert (SWEEP_ONE < (1 << CNT_W)) // R4
      else $error("length width too narrow for sweep count");
  end

  wire [CNT_W-1:0] region_lines =
    (CNT_W'(cmd_len) + CNT_W'(cmd_addr[LINE_LOG2-1:0]) + CNT_W'(LINE - 1)) >> LINE_LOG2;
  wire [CNT_W-1:0] sweep_lines = (cmd_op == OP_INVAL) ? CNT_W'(SWEEP_WAYS) : CNT_W'(SWEEP_ONE);
  wire fire = op_valid && op_ready;

  assign cmd_ready = (state == S_IDLE);
  assign op_valid  = (state == S_ISSUE);
  assign op_code   = {whole_q, op_q};
  assign op_addr   = whole_q ? base_q + (ADDR_W'(lane_q) << LINE_LOG2) : base_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      whole_q <= 1'b0;
      op_q    <= '0;
      base_q  <= '0;
      lane_q  <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          whole_q <= cmd_whole;
          op_q    <= cmd_op;
          lane_q  <= '0;
          if (cmd_whole) begin
            base_q <= '0;
            left_q <= sweep_lines;
            state  <= S_ISSUE;
          end else begin
            base_q <= cmd_addr & ~LOW_MASK;
            left_q <= region_lines;
            state  <= (region_lines == '0) ? S_SYNC : S_ISSUE;
          end
        end
        S_ISSUE: if (fire) begin
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) state <= S_SYNC;
          if (whole_q) begin
            lane_q <= lane_q + 1'b1;
            if (lane_q == 2'd3) base_q <= base_q + ADDR_W'(4 * LINE);
          end else begin
            base_q <= base_q + ADDR_W'(LINE);
          end
        end
        S_SYNC: if (!cache_busy) begin
          state  <= S_IDLE;
          done_q <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_addr) && $stable(op_code)) // R7
    else $error("request changed while stalled");
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> op_addr[LINE_LOG2-1:0] == '0) // R10
    else $error("unaligned request address");
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) // R8
    else $error("done longer than one cycle");
  AST_DONE_AFTER_IDLE_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!cache_busy)) // R8
    else $error("done while cache busy");
  AST_NO_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !op_valid && $onehot0({cmd_ready, op_valid})) // R9
    else $error("request while idle");
  AST_REGION_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !op_code[3] && left_q != CNT_W'(1) |=> op_addr == $past(op_addr) + ADDR_W'(LINE)) // R2
    else $error("region address step wrong");
endmodule

// File: tb/cache_maint_seq_bench.sv
module cache_maint_seq_bench;
  localparam int ADDR_W = 32, LEN_W = 16, CACHE = 1024, LOG2 = 4, WAYS = 2;
  localparam int LINE = 1 << LOG2;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_whole = 0, op_ready = 0, cache_busy = 0;
  logic [2:0] cmd_op = 0;
  logic [ADDR_W-1:0] cmd_addr = 0;
  logic [LEN_W-1:0] cmd_len = 0;
  logic cmd_ready, op_valid, done;
  logic [3:0] op_code;
  logic [ADDR_W-1:0] op_addr;

  int checks = 0, errors = 0, done_cnt = 0, cyc = 0;
  int stall_mode = 0;
  logic [ADDR_W+3:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  cache_maint_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CACHE_BYTES(CACHE), .LINE_LOG2(LOG2), .WAYS(WAYS))
    u_cache_maint_seq (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_whole(cmd_whole), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
      .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code), .op_addr(op_addr),
      .cache_busy(cache_busy), .done(done));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 op_ready <= (stall_mode == 0) ? 1'b1 : (cyc % 3 != 0);
  end

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (op_valid && op_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R3 unexpected request", {op_code, op_addr}, 0);
      end else begin
        logic [ADDR_W+3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({op_code, op_addr} == e, t, {op_code, op_addr}, e);
      end
    end
  end

  task automatic run_cmd(input bit whole, input logic [2:0] op, input logic [ADDR_W-1:0] addr,
                         input int len, input int hold, input bit noise, input string tag);
    int n, d0, w;
    logic [ADDR_W-1:0] base;
    if (whole) begin
      w = (op == 3'd0) ? WAYS : 1;
      n = CACHE / (LINE * w);
      for (int i = 0; i < n; i++) begin
        exp_q.push_back({1'b1, op, ADDR_W'(i * LINE)});
        tag_q.push_back(tag);
      end
    end else begin
      n = (len + int'(addr % LINE) + LINE - 1) >> LOG2;
      base = addr & ~ADDR_W'(LINE - 1);
      for (int i = 0; i < n; i++) begin
        exp_q.push_back({1'b0, op, base + ADDR_W'(i * LINE)});
        tag_q.push_back(tag);
      end
    end
    @(posedge clk); #1;
    cache_busy = (hold > 0);
    cmd_valid = 1; cmd_whole = whole; cmd_op = op; cmd_addr = addr; cmd_len = LEN_W'(len);
    @(posedge clk); #1;
    cmd_valid = 0;
    if (noise) begin
      // R9: commands presented mid-stream must be ignored
      cmd_valid = 1; cmd_whole = 1; cmd_op = 3'd4; cmd_addr = 32'hFFF0; cmd_len = 16'd300;
      repeat (5) @(posedge clk);
      #1 cmd_valid = 0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    d0 = done_cnt;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      check(done_cnt == d0, "R8 done while cache busy", done_cnt, d0);
      @(posedge clk); #1 cache_busy = 0;
    end
    for (int k = 0; k < 20 && !done; k++) @(negedge clk);
    check(done == 1'b1, {tag, " R8 done pulse"}, done, 1);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
    check(cmd_ready == 1'b1 && exp_q.size() == 0, {tag, " R9 idle after command"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(cmd_ready && !op_valid && !done, "R1 reset state", {cmd_ready, op_valid, done}, 3'b100);
    run_cmd(0, 3'd1, 32'h100, 64, 0, 0, "R2 aligned region R6");
    run_cmd(0, 3'd2, 32'h10C, 8, 0, 0, "R2 unaligned crossing R10");
    run_cmd(0, 3'd0, 32'h1234, 16, 0, 0, "R2 unaligned full line");
    run_cmd(0, 3'd3, 32'h1FF, 1, 0, 0, "R10 one byte");
    run_cmd(0, 3'd1, 32'h55, 0, 0, 0, "R3 zero length");
    run_cmd(0, 3'd4, 32'h40, 0, 4, 0, "R3 zero length busy");
    run_cmd(1, 3'd0, 32'h0, 0, 0, 0, "R4 sweep invalidate R5");
    run_cmd(1, 3'd1, 32'h0, 0, 0, 0, "R5 sweep writeback");
    stall_mode = 1;
    run_cmd(0, 3'd2, 32'h2008, 100, 0, 0, "R7 stalled region");
    run_cmd(1, 3'd4, 32'h0, 0, 0, 0, "R7 stalled sweep R4");
    run_cmd(0, 3'd1, 32'h300, 128, 0, 1, "R9 ignored command");
    stall_mode = 0;
    run_cmd(0, 3'd0, 32'h500, 32, 6, 0, "R8 busy hold");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule